// File: doc/BRIEF.md
# Guarded Halfword Load Unit

This block is a three-stage load pipeline. Each cycle it can take one request that names a byte address, a guard word and a destination tag. It reads the two bytes of the addressed halfword from a small local byte store, puts them in the order set by a run-time byte-order bit, and returns the 16-bit result zero-extended to the data width. A register write enable comes with the result. The write enable is raised only when bit 0 of the guard is set. A load whose guard bit 0 is clear passes through the pipeline with no visible effect.

An odd address or a request flagged as hitting the I/O aperture does not raise any error. Such a load returns a fixed all-ones marker, and its write enable still follows the guard. A byte-wide fill port loads the local store, which stands in for the data cache. A build parameter selects a variant with no guard, in which every issued load writes back.

Top module: `hwld_unit`

## Requirements
- R1: For a load with an even address and no aperture hit, bits [DATA_W-1:16] of `wb_data` are zero.
- R2: With `le_mode` = 0 (big-endian), `wb_data[15:8]` is the byte at the even address A and `wb_data[7:0]` is the byte at A+1. Address bits above the store index are ignored, so the store aliases.
- R3: With `le_mode` = 1 (little-endian), `wb_data[7:0]` is the byte at A and `wb_data[15:8]` is the byte at A+1.
- R4: With `GUARD_EN` = 1, `wb_en` is raised for a load only when `iss_guard[0]` is 1. All other guard bits have no effect.
- R5: With `GUARD_EN` = 0, every issued load raises `wb_en` and returns the same data as a guarded load.
- R6: A load accepted in cycle c produces its result in cycle c+3. A new load may be issued every cycle. `wb_en` is never raised in a cycle that has no such load.
- R7: An odd address returns `wb_data` = all ones, and `wb_en` follows the guard.
- R8: A load with `ap_hit` = 1 returns `wb_data` = all ones, and `wb_en` follows the guard.
- R9: Byte order is taken from `le_mode` in the cycle of issue. Toggling `le_mode` on every cycle changes only the loads issued after each change.
- R10: Synchronous active-high `rst` clears the pipeline. `wb_en` stays low while reset is held and for the first 3 cycles after it is released.
- R11: `wb_tag` equals the `iss_tag` of the load whose result is presented.
- R12: A fill write of one byte is seen by every load issued in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_vld | input | 1 | Load issue valid |
| iss_addr | input | ADDR_W | Byte address of the halfword |
| iss_guard | input | GUARD_W | Guard word; only bit 0 matters |
| iss_tag | input | TAG_W | Destination register tag |
| le_mode | input | 1 | 1 = little-endian, 0 = big-endian |
| ap_hit | input | 1 | Load targets the I/O aperture |
| fill_en | input | 1 | Write one byte into the local store |
| fill_addr | input | ADDR_W | Byte address of the fill |
| fill_data | input | 8 | Fill byte |
| wb_en | output | 1 | Register write enable |
| wb_tag | output | TAG_W | Destination tag of the result |
| wb_data | output | DATA_W | Zero-extended halfword or the all-ones marker |

## Verification
The assertions check, on every cycle, the timing and control side of the result. They check that the write enable appears three cycles after a guarded issue and at no other time, that the tag matches the issue, that odd or aperture loads give the marker, that the upper bits are zero otherwise, and that the output stays quiet just after reset. The values of the data bytes depend on the store contents and on the byte-order bit, so only the bench scenarios can show them. These scenarios are aligned loads in both byte orders, a byte order that toggles every cycle, aliasing through the upper address bits, reads right after fills, and the unguarded variant.

// File: rtl/hwld_pkg.sv
package hwld_pkg;
   localparam int BYTE_W = 8;
   localparam int HW_W   = 16;
   localparam int LANES  = HW_W / BYTE_W;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic {
      ORDER_BIG    = 1'b0,
      ORDER_LITTLE = 1'b1
   } order_e;
endpackage

// File: rtl/hwld_issue.sv
module hwld_issue
   import hwld_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int GUARD_W  = 32,
   parameter int TAG_W    = 5,
   parameter int IDX_W    = 8,
   parameter bit GUARD_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               iss_vld,
   input  logic [ADDR_W-1:0]  iss_addr,
   input  logic [GUARD_W-1:0] iss_guard,
   input  logic [TAG_W-1:0]   iss_tag,
   input  logic               le_mode,
   input  logic               ap_hit,
   output logic               s1_vld,
   output logic               s1_wr,
   output logic [TAG_W-1:0]   s1_tag,
   output logic               s1_le,
   output logic               s1_bad,
   output logic [IDX_W-2:0]   s1_row
);
   logic take;
   logic unused_issue_bits;

   generate
      if (GUARD_EN) begin : g_guarded
         assign take = iss_guard[0];
      end else begin : g_open
         assign take = 1'b1;
      end
   endgenerate

   assign unused_issue_bits = ^{iss_guard, iss_addr};

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld <= 1'b0;
         s1_wr  <= 1'b0;
         s1_tag <= '0;
         s1_le  <= 1'b0;
         s1_bad <= 1'b0;
         s1_row <= '0;
      end else begin
         s1_vld <= iss_vld;
         s1_wr  <= iss_vld && take;
         s1_tag <= iss_tag;
         s1_le  <= le_mode;
         s1_bad <= iss_addr[0] | ap_hit;
         s1_row <= iss_addr[IDX_W-1:1];
      end
   end
endmodule

// File: rtl/hwld_lane_mem.sv
module hwld_lane_mem
   import hwld_pkg::*;
#(
   parameter int ROW_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  byte_t            wr_byte,
   input  logic             rd_en,
   input  logic [ROW_W-1:0] rd_row,
   output byte_t            rd_byte
);
   localparam int ROWS = 1 << ROW_W;

   byte_t cells [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_row] <= wr_byte;
   end

   always_ff @(posedge clk) begin
      if (rst)        rd_byte <= '0;
      else if (rd_en) rd_byte <= cells[rd_row];
   end
endmodule

// File: rtl/hwld_format.sv
module hwld_format
   import hwld_pkg::*;
#(
   parameter int TAG_W  = 5,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         s2_wr,
   input  logic [TAG_W-1:0]             s2_tag,
   input  logic                         s2_le,
   input  logic                         s2_bad,
   input  logic [LANES-1:0][BYTE_W-1:0] lane_q,
   output logic                         wb_en,
   output logic [TAG_W-1:0]             wb_tag,
   output logic [DATA_W-1:0]            wb_data
);
   localparam logic [DATA_W-1:0] MARK = '1;
   localparam int PAD_W = DATA_W - HW_W;

   logic [HW_W-1:0] hw;
   order_e order;

   assign order = order_e'(s2_le);

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_byte
         assign hw[BYTE_W*j +: BYTE_W] = (order == ORDER_LITTLE) ? lane_q[j]
                                                                 : lane_q[LANES-1-j];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         wb_en   <= 1'b0;
         wb_tag  <= '0;
         wb_data <= '0;
      end else begin
         wb_en   <= s2_wr;
         wb_tag  <= s2_tag;
         wb_data <= s2_bad ? MARK : {{PAD_W{1'b0}}, hw};
      end
   end
endmodule

// File: rtl/hwld_unit.sv
module hwld_unit
   import hwld_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int GUARD_W   = 32,
   parameter int TAG_W     = 5,
   parameter int MEM_BYTES = 256,
   parameter bit GUARD_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               iss_vld,
   input  logic [ADDR_W-1:0]  iss_addr,
   input  logic [GUARD_W-1:0] iss_guard,
   input  logic [TAG_W-1:0]   iss_tag,
   input  logic               le_mode,
   input  logic               ap_hit,
   input  logic               fill_en,
   input  logic [ADDR_W-1:0]  fill_addr,
   input  logic [7:0]         fill_data,
   output logic               wb_en,
   output logic [TAG_W-1:0]   wb_tag,
   output logic [DATA_W-1:0]  wb_data
);
   localparam int IDX_W = $clog2(MEM_BYTES);
   localparam int ROW_W = IDX_W - 1;

   generate
      if ((1 << IDX_W) != MEM_BYTES || MEM_BYTES < 4) begin : g_bad_depth
         $error("hwld_unit: MEM_BYTES must be a power of two of at least 4");
      end
      if (DATA_W <= HW_W) begin : g_bad_data
         $error("hwld_unit: DATA_W must exceed the halfword width");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("hwld_unit: ADDR_W too narrow for MEM_BYTES");
      end
      if (TAG_W < 1 || GUARD_W < 1) begin : g_bad_tag
         $error("hwld_unit: TAG_W and GUARD_W must be positive");
      end
   endgenerate

   logic             s1_vld, s1_wr, s1_le, s1_bad;
   logic [TAG_W-1:0] s1_tag;
   logic [ROW_W-1:0] s1_row;

   logic             s2_wr, s2_le, s2_bad;
   logic [TAG_W-1:0] s2_tag;

   logic [LANES-1:0][BYTE_W-1:0] lane_q;
   logic unused_fill_bits;

   assign unused_fill_bits = ^fill_addr;

   hwld_issue #(
      .ADDR_W  (ADDR_W),
      .GUARD_W (GUARD_W),
      .TAG_W   (TAG_W),
      .IDX_W   (IDX_W),
      .GUARD_EN(GUARD_EN)
   ) u_issue (
      .clk      (clk),
      .rst      (rst),
      .iss_vld  (iss_vld),
      .iss_addr (iss_addr),
      .iss_guard(iss_guard),
      .iss_tag  (iss_tag),
      .le_mode  (le_mode),
      .ap_hit   (ap_hit),
      .s1_vld   (s1_vld),
      .s1_wr    (s1_wr),
      .s1_tag   (s1_tag),
      .s1_le    (s1_le),
      .s1_bad   (s1_bad),
      .s1_row   (s1_row)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic lane_wr;
         assign lane_wr = fill_en && (fill_addr[0] == 1'(l));
         hwld_lane_mem #(.ROW_W(ROW_W)) u_mem (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (lane_wr),
            .wr_row (fill_addr[IDX_W-1:1]),
            .wr_byte(fill_data),
            .rd_en  (s1_vld),
            .rd_row (s1_row),
            .rd_byte(lane_q[l])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_wr  <= 1'b0;
         s2_tag <= '0;
         s2_le  <= 1'b0;
         s2_bad <= 1'b0;
      end else begin
         s2_wr  <= s1_wr;
         s2_tag <= s1_tag;
         s2_le  <= s1_le;
         s2_bad <= s1_bad;
      end
   end

   hwld_format #(
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
   ) u_fmt (
      .clk    (clk),
      .rst    (rst),
      .s2_wr  (s2_wr),
      .s2_tag (s2_tag),
      .s2_le  (s2_le),
      .s2_bad (s2_bad),
      .lane_q (lane_q),
      .wb_en  (wb_en),
      .wb_tag (wb_tag),
      .wb_data(wb_data)
   );
endmodule

// File: rtl/hwld_unit_chk.sv
module hwld_unit_chk #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int GUARD_W  = 32,
   parameter int TAG_W    = 5,
   parameter bit GUARD_EN = 1'b1
) (
   input logic               clk,
   input logic               rst,
   input logic               iss_vld,
   input logic [ADDR_W-1:0]  iss_addr,
   input logic [GUARD_W-1:0] iss_guard,
   input logic [TAG_W-1:0]   iss_tag,
   input logic               ap_hit,
   input logic               wb_en,
   input logic [TAG_W-1:0]   wb_tag,
   input logic [DATA_W-1:0]  wb_data
);
   logic [1:0] since_rst;
   logic       warm, take, odd;
   logic       unused_chk_bits;

   assign warm = (since_rst == 2'd3);
   assign take = iss_vld && (iss_guard[0] || !GUARD_EN);
   assign odd  = iss_addr[0];
   assign unused_chk_bits = ^{iss_addr, iss_guard};

   always_ff @(posedge clk) begin
      if (rst)                 since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) !warm |-> !wb_en); // R10
   AST_WB_NEEDS_GUARD: assert property (@(posedge clk) disable iff (rst) (warm && wb_en) |-> $past(take, 3)); // R4
   AST_WB_EVERY_TAKE: assert property (@(posedge clk) disable iff (rst) (warm && $past(take, 3)) |-> wb_en); // R6
   AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (warm && wb_en) |-> (wb_tag == $past(iss_tag, 3))); // R11
   AST_MARKER_ON_ODD: assert property (@(posedge clk) disable iff (rst) (warm && wb_en && $past(odd, 3)) |-> (wb_data == '1)); // R7
   AST_MARKER_ON_APERTURE: assert property (@(posedge clk) disable iff (rst) (warm && wb_en && $past(ap_hit, 3)) |-> (wb_data == '1)); // R8
   AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst) (warm && wb_en && !$past(odd | ap_hit, 3)) |-> (wb_data[DATA_W-1:16] == '0)); // R1
endmodule

bind hwld_unit hwld_unit_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .GUARD_W (GUARD_W),
   .TAG_W   (TAG_W),
   .GUARD_EN(GUARD_EN)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .iss_vld  (iss_vld),
   .iss_addr (iss_addr),
   .iss_guard(iss_guard),
   .iss_tag  (iss_tag),
   .ap_hit   (ap_hit),
   .wb_en    (wb_en),
   .wb_tag   (wb_tag),
   .wb_data  (wb_data)
);

// File: tb/tb_hwld_unit.sv
module tb_hwld_unit;
   localparam int CLK_P = 10;

   logic        clk, rst;
   logic        iss_vld, le_mode, ap_hit, fill_en;
   logic [31:0] iss_addr, iss_guard, fill_addr;
   logic [4:0]  iss_tag;
   logic [7:0]  fill_data;
   logic        wb_en, ng_wb_en;
   logic [4:0]  wb_tag, ng_wb_tag;
   logic [31:0] wb_data, ng_wb_data;

   hwld_unit dut (
      .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_addr(iss_addr),
      .iss_guard(iss_guard), .iss_tag(iss_tag), .le_mode(le_mode),
      .ap_hit(ap_hit), .fill_en(fill_en), .fill_addr(fill_addr),
      .fill_data(fill_data), .wb_en(wb_en), .wb_tag(wb_tag), .wb_data(wb_data)
   );

   hwld_unit #(.GUARD_EN(1'b0)) dut_ng (
      .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_addr(iss_addr),
      .iss_guard(iss_guard), .iss_tag(iss_tag), .le_mode(le_mode),
      .ap_hit(ap_hit), .fill_en(fill_en), .fill_addr(fill_addr),
      .fill_data(fill_data), .wb_en(ng_wb_en), .wb_tag(ng_wb_tag),
      .wb_data(ng_wb_data)
   );

   typedef struct {
      bit          en;
      bit          en2;
      logic [4:0]  tag;
      logic [31:0] data;
      string       req;
   } exp_t;

   exp_t q[$];
   int   mem_m [256];
   int   vectors = 0;
   int   miscompares = 0;

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_load(input logic [31:0] a, input bit le, input bit ap);
      int sel, base;
      logic [7:0] lo, hi;
      if (a[0] || ap) return 32'hFFFF_FFFF;
      sel  = le ? 1 : 0;
      base = int'(a[7:0]);
      lo   = 8'(mem_m[base + (1 ^ sel)]);
      hi   = 8'(mem_m[base + (0 ^ sel)]);
      return {16'h0000, hi, lo};
   endfunction

   task automatic compare_out();
      exp_t o;
      o = q.pop_front();
      chk(wb_en == o.en, o.req, "wb_en", 32'(wb_en), 32'(o.en));
      if (o.en) begin
         chk(wb_tag == o.tag, "R11", "wb_tag", 32'(wb_tag), 32'(o.tag));
         chk(wb_data == o.data, o.req, "wb_data", wb_data, o.data);
      end
      chk(ng_wb_en == o.en2, "R5", "unguarded wb_en", 32'(ng_wb_en), 32'(o.en2));
      if (o.en2) begin
         chk(ng_wb_data == o.data, "R5", "unguarded wb_data", ng_wb_data, o.data);
      end
   endtask

   task automatic cyc(input bit v, input logic [31:0] a, input logic [31:0] g,
                      input logic [4:0] t, input bit le, input bit ap, input string req);
      exp_t e;
      iss_vld   = v;
      iss_addr  = a;
      iss_guard = g;
      iss_tag   = t;
      le_mode   = le;
      ap_hit    = ap;
      fill_en   = 1'b0;
      e.en   = v && g[0];
      e.en2  = v;
      e.tag  = t;
      e.data = expect_load(a, le, ap);
      e.req  = req;
      q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      iss_vld = 1'b0;
      compare_out();
   endtask

   task automatic fill(input int a, input int d);
      exp_t e;
      iss_vld   = 1'b0;
      fill_en   = 1'b1;
      fill_addr = 32'(a);
      fill_data = 8'(d);
      e.en = 1'b0; e.en2 = 1'b0; e.tag = '0; e.data = '0; e.req = "R6";
      q.push_back(e);
      mem_m[a & 255] = d & 255;
      @(posedge clk);
      @(negedge clk);
      fill_en = 1'b0;
      compare_out();
   endtask

   initial begin
      #(CLK_P * 200000);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      exp_t idle;
      for (int i = 0; i < 256; i++) mem_m[i] = 0;
      rst = 1'b1; iss_vld = 1'b0; iss_addr = '0; iss_guard = '0; iss_tag = '0;
      le_mode = 1'b0; ap_hit = 1'b0; fill_en = 1'b0; fill_addr = '0; fill_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(wb_en == 1'b0, "R10", "wb_en in reset", 32'(wb_en), 32'd0);
      chk(ng_wb_en == 1'b0, "R10", "unguarded wb_en in reset", 32'(ng_wb_en), 32'd0);
      rst = 1'b0;
      idle.en = 1'b0; idle.en2 = 1'b0; idle.tag = '0; idle.data = '0; idle.req = "R10";
      q.push_back(idle);
      q.push_back(idle);

      for (int i = 0; i < 64; i++) fill(i, (i * 37 + 11) % 256);
      fill(0, 'h22); fill(1, 'h11); fill(4, 'h84); fill(5, 'h33);

      cyc(1, 32'h0, 32'h1, 5'd3, 1'b0, 1'b0, "R2");          // 0x00002211
      cyc(1, 32'h4, 32'h0, 5'd4, 1'b0, 1'b0, "R4");          // guard clear
      cyc(1, 32'h4, 32'h1, 5'd5, 1'b0, 1'b0, "R2");          // 0x00008433
      cyc(1, 32'h4, 32'hFFFF_FFFE, 5'd6, 1'b0, 1'b0, "R4");  // upper bits set, lsb clear
      cyc(1, 32'h4, 32'h8000_0003, 5'd7, 1'b0, 1'b0, "R4");
      cyc(1, 32'h0, 32'h1, 5'd8, 1'b1, 1'b0, "R3");          // 0x00001122
      cyc(1, 32'h4, 32'h1, 5'd9, 1'b1, 1'b0, "R3");          // 0x00003384
      cyc(1, 32'hABCD_0000, 32'h1, 5'd10, 1'b0, 1'b0, "R2"); // aliases to 0
      cyc(1, 32'h10, 32'h1, 5'd11, 1'b0, 1'b0, "R1");

      for (int i = 0; i < 16; i++)
         cyc(1, 32'(16 + 2 * i), 32'h1, 5'(i), (i % 2) == 1, 1'b0, "R9");

      cyc(1, 32'h3, 32'h1, 5'd12, 1'b0, 1'b0, "R7");
      cyc(1, 32'h3, 32'h0, 5'd13, 1'b0, 1'b0, "R7");
      cyc(1, 32'h21, 32'h1, 5'd14, 1'b1, 1'b0, "R7");
      cyc(1, 32'h0, 32'h1, 5'd15, 1'b0, 1'b1, "R8");
      cyc(1, 32'h4, 32'h0, 5'd16, 1'b1, 1'b1, "R8");
      cyc(1, 32'h6, 32'h1, 5'd17, 1'b1, 1'b1, "R8");

      fill('h30, 'h5A); fill('h31, 'hC3);
      cyc(1, 32'h30, 32'h1, 5'd18, 1'b0, 1'b0, "R12");      // 0x00005AC3
      cyc(1, 32'h30, 32'h1, 5'd19, 1'b1, 1'b0, "R12");      // 0x0000C35A

      for (int i = 0; i < 6; i++) cyc(1, 32'(8 + 2 * i), 32'(i % 2), 5'(20 + i), 1'b0, 1'b0, "R6");
      repeat (3) cyc(0, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, "R6");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule